// File: doc/BRIEF.md
# Sticky Object Collision Latch Unit

This block watches six graphic objects on a raster display and records which of them have overlapped. The objects are two players, two missiles, a ball and the playfield. A one-bit activity flag for each object arrives with every pixel clock, together with a flag that marks the visible part of the frame.

For every unordered pair of objects there is a hit detector, fifteen in all. When both objects of a pair are active on a visible pixel, the detector sets a sticky latch. The latch keeps its value until software clears it.

Software reads the latches through eight byte-wide read registers on a small CPU bus. Each register carries up to two flags in its two top data bits. A write to one dedicated address clears all fifteen latches at once, whatever data is written. Read data is combinational from the address and shows the latch state as it stood after the most recent clock edge.

Top module: `collision_unit`

## Requirements
- R1: After reset every latch is clear, and a read of any of register addresses 0 to 7 returns 0x00.
- R2: When `visible` is high and both objects of a pair are high in `objActive` at a rising edge, that pair's latch is set and can be read from the next cycle on. Object bit positions in `objActive`: 0 = player 0, 1 = player 1, 2 = missile 0, 3 = missile 1, 4 = ball, 5 = playfield. A single active object sets nothing.
- R3: While `visible` is low, no latch is set, whatever `objActive` carries.
- R4: A set latch stays set after its objects stop overlapping, until a clear.
- R5: Address 0 reads missile0/player1 in bit 7 and missile0/player0 in bit 6. Address 1 reads missile1/player0 in bit 7 and missile1/player1 in bit 6.
- R6: Addresses 2, 3, 4 and 5 belong to player 0, player 1, missile 0 and missile 1, in that order. Each reads the hit with the playfield in bit 7 and the hit with the ball in bit 6.
- R7: Address 6 reads ball/playfield in bit 7, and bit 6 is always 0. Address 7 reads player0/player1 in bit 7 and missile0/missile1 in bit 6.
- R8: Data bits 5 to 0 always read 0. A read of any address of 8 or above returns 0x00, and `rdData` is 0x00 whenever no read is in progress.
- R9: A bus write to address 0x2C clears every latch at the next edge. A write to any other address changes no latch.
- R10: If a clear write and a set condition fall in the same cycle, the latch ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| visible | input | 1 | High on pixels inside the visible region |
| objActive | input | 6 | Per-object activity flags for the current pixel |
| busSel | input | 1 | Bus access in progress this cycle |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 6 | Register address |
| rdData | output | 8 | Read data; 0 when no read is in progress |

## Verification
A clear-all write and a new overlap can arrive in the same cycle. The bench provokes this both directly and at random: it issues the clear write while the objects of one or more pairs are active on a visible pixel. It then reads every register in the following cycles and expects each flag to read 0, with clear taking precedence over set. The flags are compared against a bench model that applies the same precedence rule.

// File: rtl/collision_pkg.sv
package collision_pkg;

  localparam int NUM_OBJ   = 6;
  localparam int NUM_REG   = 8;
  localparam int NUM_SLOT  = 2 * NUM_REG;
  localparam int REG_SEL_W = $clog2(NUM_REG);

  // Object positions inside the activity vector
  localparam int OBJ_P0 = 0;
  localparam int OBJ_P1 = 1;
  localparam int OBJ_M0 = 2;
  localparam int OBJ_M1 = 3;
  localparam int OBJ_BL = 4;
  localparam int OBJ_PF = 5;

  localparam int UNUSED_SLOT = 12;

  typedef struct packed {
    logic                 clearAll;
    logic                 readEn;
    logic [REG_SEL_W-1:0] readSel;
  } ctrlStrobes_t;

  // Slot index = register * 2 + (1 for data bit 7, 0 for data bit 6).
  // Returns {objectA, objectB} packed as two 4-bit fields.
  function automatic logic [7:0] slotPair(input int slot);
    logic [7:0] p;
    case (slot)
      0:  p = {4'(OBJ_M0), 4'(OBJ_P0)};
      1:  p = {4'(OBJ_M0), 4'(OBJ_P1)};
      2:  p = {4'(OBJ_M1), 4'(OBJ_P1)};
      3:  p = {4'(OBJ_M1), 4'(OBJ_P0)};
      4:  p = {4'(OBJ_P0), 4'(OBJ_BL)};
      5:  p = {4'(OBJ_P0), 4'(OBJ_PF)};
      6:  p = {4'(OBJ_P1), 4'(OBJ_BL)};
      7:  p = {4'(OBJ_P1), 4'(OBJ_PF)};
      8:  p = {4'(OBJ_M0), 4'(OBJ_BL)};
      9:  p = {4'(OBJ_M0), 4'(OBJ_PF)};
      10: p = {4'(OBJ_M1), 4'(OBJ_BL)};
      11: p = {4'(OBJ_M1), 4'(OBJ_PF)};
      13: p = {4'(OBJ_BL), 4'(OBJ_PF)};
      14: p = {4'(OBJ_M0), 4'(OBJ_M1)};
      15: p = {4'(OBJ_P0), 4'(OBJ_P1)};
      default: p = 8'h00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/collision_ctrl.sv
module collision_ctrl
  import collision_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 6'h2C
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REG);

  logic isRead;
  logic isWrite;

  always_comb begin
    isRead  = busSel && !busWrite;
    isWrite = busSel && busWrite;
    strobes.clearAll = isWrite && (busAddr == CLEAR_ADDR);
    strobes.readEn   = isRead && (busAddr < REG_LIMIT);
    strobes.readSel  = busAddr[REG_SEL_W-1:0];
  end

endmodule

// File: rtl/collision_datapath.sv
module collision_datapath
  import collision_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                visible,
  input  logic [NUM_OBJ-1:0]  objActive,
  input  ctrlStrobes_t        strobes,
  output logic [NUM_SLOT-1:0] hitFlags,
  output logic [DATA_W-1:0]   rdData
);

  localparam int PAD_W = DATA_W - 2;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    if (s == UNUSED_SLOT) begin : g_none
      assign hitFlags[s] = 1'b0;
    end else begin : g_pair
      localparam logic [7:0] PAIR = slotPair(s);
      localparam int OBJ_A = int'(PAIR[7:4]);
      localparam int OBJ_B = int'(PAIR[3:0]);
      logic pairHit;
      logic flagQ;
      assign pairHit = visible && objActive[OBJ_A] && objActive[OBJ_B];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 flagQ <= 1'b0;
        else if (strobes.clearAll) flagQ <= 1'b0;
        else if (pairHit)          flagQ <= 1'b1;
      end
      assign hitFlags[s] = flagQ;
    end
  end

  logic hiBit;
  logic loBit;

  always_comb begin
    hiBit = hitFlags[{strobes.readSel, 1'b1}];
    loBit = hitFlags[{strobes.readSel, 1'b0}];
    if (strobes.readEn) rdData = {hiBit, loBit, PAD_W'(0)};
    else                rdData = '0;
  end

endmodule

// File: rtl/collision_unit.sv
module collision_unit
  import collision_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 6'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              visible,
  input  logic [5:0]        objActive,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobes_t        ctrlBus;
  logic [NUM_SLOT-1:0] hitFlags;

  collision_ctrl #(
    .ADDR_W    (ADDR_W),
    .CLEAR_ADDR(CLEAR_ADDR)
  ) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobes (ctrlBus)
  );

  collision_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .visible  (visible),
    .objActive(objActive),
    .strobes  (ctrlBus),
    .hitFlags (hitFlags),
    .rdData   (rdData)
  );

endmodule

// File: rtl/collision_unit_chk.sv
module collision_unit_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 6'h2C
) (
  input logic              clk,
  input logic              rstN,
  input logic              visible,
  input logic [5:0]        objActive,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [15:0]       hitFlags
);

  logic clearReq;
  assign clearReq = busSel && busWrite && (busAddr == CLEAR_ADDR);

  // R9 / R10: a clear write leaves every latch clear, even with overlaps present
  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (hitFlags == 16'h0000));

  // R4: without a clear, no set latch ever drops
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> ((hitFlags & $past(hitFlags)) == $past(hitFlags)));

  // R3: outside the visible region the latches hold
  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!visible && !clearReq) |=> (hitFlags == $past(hitFlags)));

  // R2: player0 and player1 overlapping on a visible pixel set their latch (slot 15)
  assert_p0p1_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (visible && objActive[0] && objActive[1] && !clearReq) |=> hitFlags[15]);

  // R8: the low data bits never carry anything
  assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-3:0] == '0);

  // R8: no read in progress means an idle data bus
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> (rdData == '0));

  // R7: address 6 bit 6 reads zero
  assert_unused_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == ADDR_W'(6)) |-> !rdData[DATA_W-2]);

endmodule

bind collision_unit collision_unit_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .visible  (visible),
  .objActive(objActive),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .rdData   (rdData),
  .hitFlags (hitFlags)
);

// File: tb/collision_unit_test.sv
module collision_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       visible = 1'b0;
  logic [5:0] objActive = 6'h00;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [5:0] busAddr = 6'h00;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit expFlag [16];
  bit finished = 1'b0;

  collision_unit uut (
    .clk      (clk),
    .rstN     (rstN),
    .visible  (visible),
    .objActive(objActive),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .rdData   (rdData)
  );

  always #5 clk = ~clk;

  // Bench pair table: slot = addr*2 + (1 for bit 7). Objects: P0=0 P1=1 M0=2 M1=3 BL=4 PF=5
  function automatic bit slotObjs(input int s, output int a, output int b);
    a = 0; b = 0;
    case (s)
      1:  begin a = 2; b = 1; end   // addr0 bit7 M0-P1
      0:  begin a = 2; b = 0; end   // addr0 bit6 M0-P0
      3:  begin a = 3; b = 0; end   // addr1 bit7 M1-P0
      2:  begin a = 3; b = 1; end   // addr1 bit6 M1-P1
      5:  begin a = 0; b = 5; end
      4:  begin a = 0; b = 4; end
      7:  begin a = 1; b = 5; end
      6:  begin a = 1; b = 4; end
      9:  begin a = 2; b = 5; end
      8:  begin a = 2; b = 4; end
      11: begin a = 3; b = 5; end
      10: begin a = 3; b = 4; end
      13: begin a = 4; b = 5; end
      15: begin a = 0; b = 1; end
      14: begin a = 2; b = 3; end
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  function automatic logic [7:0] expRead(input bit sel, input bit wr, input int addr);
    if (!sel || wr || addr >= 8) return 8'h00;
    return {expFlag[addr*2+1], expFlag[addr*2], 6'b0};
  endfunction

  function automatic string tagOf(input int addr);
    if (addr < 2) return "R5";
    if (addr < 6) return "R6";
    if (addr < 8) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, busAddr, rdData, exp);
    end
  endtask

  task automatic modelEdge();
    int a, b;
    if (busSel && busWrite && busAddr == 6'h2C) begin
      foreach (expFlag[i]) expFlag[i] = 1'b0;
    end else if (visible) begin
      for (int s = 0; s < 16; s++)
        if (slotObjs(s, a, b) && objActive[a] && objActive[b]) expFlag[s] = 1'b1;
    end
  endtask

  // one cycle: drive at negedge, check before next posedge, then advance the model
  task automatic step(input bit vis, input logic [5:0] obj, input bit sel, input bit wr,
                      input int addr, input string tag);
    @(negedge clk);
    visible = vis; objActive = obj; busSel = sel; busWrite = wr; busAddr = 6'(addr);
    #1;
    check(tag, expRead(sel, wr, addr));
    modelEdge();
  endtask

  task automatic readAll(input string tag);
    for (int r = 0; r < 8; r++) step(1'b0, 6'h3F, 1'b1, 1'b0, r, tag);
  endtask

  task automatic clearAll();
    step(1'b0, 6'h00, 1'b1, 1'b1, 6'h2C, "R9");
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int a, b;
    void'($urandom(32'h1234_5678));
    foreach (expFlag[i]) expFlag[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readAll("R1");

    // R2, R5, R6, R7: each pair alone, then every register read back
    for (int s = 0; s < 16; s++) begin
      if (slotObjs(s, a, b)) begin
        clearAll();
        step(1'b1, 6'((1 << a) | (1 << b)), 1'b0, 1'b0, 0, "R2");
        readAll(tagOf(s / 2));
      end
    end

    // R2: a single object sets nothing
    clearAll();
    for (int o = 0; o < 6; o++) step(1'b1, 6'(1 << o), 1'b0, 1'b0, 0, "R2");
    readAll("R2");

    // R3: full overlap during blanking sets nothing
    step(1'b0, 6'h3F, 1'b0, 1'b0, 0, "R3");
    step(1'b0, 6'h3F, 1'b0, 1'b0, 0, "R3");
    readAll("R3");

    // R4: set then separate, then long idle
    step(1'b1, 6'h03, 1'b0, 1'b0, 0, "R4");
    repeat (5) step(1'b1, 6'h00, 1'b0, 1'b0, 0, "R4");
    step(1'b0, 6'h00, 1'b1, 1'b0, 7, "R4");

    // R9: non-clear writes leave latches alone
    step(1'b1, 6'h3F, 1'b0, 1'b0, 0, "R9");
    step(1'b0, 6'h00, 1'b1, 1'b1, 6'h2B, "R9");
    step(1'b0, 6'h00, 1'b1, 1'b1, 6'h2D, "R9");
    step(1'b0, 6'h00, 1'b1, 1'b1, 6'h0C, "R9");
    readAll("R9");
    clearAll();
    readAll("R9");

    // R10: clear coincides with full overlap
    step(1'b1, 6'h3F, 1'b1, 1'b1, 6'h2C, "R10");
    readAll("R10");

    // R8: out-of-range reads and idle bus
    step(1'b1, 6'h3F, 1'b0, 1'b0, 0, "R8");
    for (int r = 8; r < 64; r += 7) step(1'b0, 6'h00, 1'b1, 1'b0, r, "R8");
    step(1'b0, 6'h00, 1'b0, 1'b0, 3, "R8");
    step(1'b0, 6'h00, 1'b1, 1'b1, 3, "R8");

    // Random traffic, sparse objects so latches fill slowly, regular clears
    for (int i = 0; i < 4000; i++) begin
      int kind;
      int addr;
      logic [5:0] obj;
      bit vis;
      kind = int'($urandom_range(0, 19));
      obj  = 6'($urandom) & 6'($urandom) & 6'($urandom);
      vis  = ($urandom_range(0, 3) != 0);
      if (kind == 0) begin
        step(vis, obj, 1'b1, 1'b1, 6'h2C, "R10");
      end else if (kind == 1) begin
        addr = int'($urandom_range(0, 63));
        step(vis, obj, 1'b1, 1'b1, addr, "R9");
      end else if (kind < 16) begin
        addr = int'($urandom_range(0, 9));
        step(vis, obj, 1'b1, 1'b0, addr, tagOf(addr));
      end else begin
        step(vis, obj, 1'b0, 1'b0, 0, "R8");
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule